// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Gate Logic

This block sits between three digitized Hall sensor bits and the six gate-drive enables of a bipolar three-phase bridge. Each clock it picks one phase to source current through its high-side switch and one phase to sink it through its low-side switch. The choice follows the Hall code and a direction select. Chopping by the PWM carrier gate is applied only to the high-side enables. The low-side enable of the active step stays steadily on.

A run/stop input chooses between commutation and a stopped state. When stopped, a brake-select input picks one of two behaviours. The motor can coast with every switch open. Or it can short-brake, with every high-side switch closed at full duty and every low-side switch open. A current-limit comparator flag trims the high-side on time, one PWM period at a time. A fault input (undervoltage or stall) removes all high-side drive. Any change in which switches are enabled inserts a dead gap, so the bridge breaks before it makes. All six outputs are registered, one clock after the inputs they follow.

Top module: `hall_gate_driver`

## Requirements
- R1: In run with direction low (forward), the Hall code {hall_i[2],hall_i[1],hall_i[0]} maps to (high-side phase, low-side phase) as: 101→(V,U), 100→(W,U), 110→(W,V), 010→(U,V), 011→(U,W), 001→(V,W). Output bit 0 is phase U, bit 1 is V and bit 2 is W.
- R2: With direction high (reverse), the bitwise complement of the Hall code is looked up in the table of R1.
- R3: In run, the selected high-side output follows the PWM gate. The selected low-side output stays on for every cycle of the step.
- R4: A low run/stop input (stop_i=0) runs the motor. A high one stops commutation whatever the Hall code is.
- R5: Stopped with coast_i=0 short-brakes: gate_hi_o=111 and gate_lo_o=000, independent of the PWM gate and the Hall code.
- R6: Stopped with coast_i=1 drives all six outputs low.
- R7: In run, a high current-limit flag turns the high-side outputs off in the same output cycle. The trip stays latched until the next rising edge of the PWM gate, at which point drive resumes.
- R8: The current-limit flag has no effect while braking.
- R9: A high fault input forces all high-side outputs off, both in run and in brake. The low-side outputs are unaffected.
- R10: In run, the Hall codes 000 and 111 drive all six outputs low.
- R11: When the set of enabled switches changes (new step, direction flip, or mode change), all outputs are low for DEAD_CYCLES (default 1) output cycles before the new set appears.
- R12: After reset all outputs are low. The high-side and low-side outputs of the same phase are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_i | input | 3 | Digitized Hall bits, bit 2 is the first sensor |
| pwm_i | input | 1 | PWM carrier gate, high = on phase of the period |
| dir_rev_i | input | 1 | 0 = forward, 1 = reverse |
| stop_i | input | 1 | 0 = run, 1 = stop |
| coast_i | input | 1 | When stopped: 1 = coast, 0 = short brake |
| ilim_i | input | 1 | Current-limit comparator flag |
| fault_i | input | 1 | Undervoltage or stall shutdown |
| gate_hi_o | output | 3 | High-side enables {W,V,U} |
| gate_lo_o | output | 3 | Low-side enables {W,V,U} |

## Verification
The commutation table is exercised with a full forward sweep of the six valid codes, then a reverse sweep. Mismatches between these sweeps separate a bad table entry from a bad complement. The PWM gate is toggled within one step, which separates high-side chopping from a low side that should stay steady. A current-limit pulse in the middle of a period, followed by further carrier cycles, shows whether the trip holds to the period edge and releases there. Stopped runs with the limit flag, the fault input and both brake selections separate braking, coasting and fault priority. Direction flips and mode changes in mid-step show the one-cycle dead gap.

// File: rtl/hgd_pkg.sv
package hgd_pkg;
  localparam int PHASES = 3;
  localparam int HALL_W = 3;

  typedef struct packed {
    logic [PHASES-1:0] src;
    logic [PHASES-1:0] snk;
  } drive_pat_t;

  localparam drive_pat_t PAT_OFF   = '0;
  localparam drive_pat_t PAT_BRAKE = '{src: '1, snk: '0};
endpackage

// File: rtl/hgd_hall_decode.sv
module hgd_hall_decode
  import hgd_pkg::*;
(
  input  logic [HALL_W-1:0] hall_i,
  input  logic              rev_i,
  output drive_pat_t        pat_o,
  output logic              valid_o
);
  logic [HALL_W-1:0] code;

  // reverse rotation: complement the code, reuse the forward table
  assign code = rev_i ? ~hall_i : hall_i;

  always_comb begin
    valid_o = 1'b1;
    unique case (code)
      3'b101: pat_o = '{src: 3'b010, snk: 3'b001};
      3'b100: pat_o = '{src: 3'b100, snk: 3'b001};
      3'b110: pat_o = '{src: 3'b100, snk: 3'b010};
      3'b010: pat_o = '{src: 3'b001, snk: 3'b010};
      3'b011: pat_o = '{src: 3'b001, snk: 3'b100};
      3'b001: pat_o = '{src: 3'b010, snk: 3'b100};
      default: begin
        pat_o   = PAT_OFF;
        valid_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hgd_chop_ctrl.sv
module hgd_chop_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic pwm_i,
  input  logic ilim_i,
  input  logic fault_i,
  input  logic brake_i,
  output logic chop_ok_o
);
  logic pwm_d;
  logic trip_q;
  logic period_start;
  logic trip_eff;

  assign period_start = pwm_i & ~pwm_d;
  assign trip_eff     = trip_q & ~period_start;

  // braking: full duty, limiter bypassed; fault always wins
  assign chop_ok_o = brake_i ? ~fault_i
                             : (pwm_i & ~ilim_i & ~trip_eff & ~fault_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_d  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      pwm_d <= pwm_i;
      if (ilim_i)            trip_q <= 1'b1;
      else if (period_start) trip_q <= 1'b0;
    end
  end

  // R7: a latched trip with no new period edge keeps drive blocked
  a_r7_trip_blocks : assert property (@(posedge clk) disable iff (rst)
    (trip_q && !period_start && !brake_i) |-> !chop_ok_o);
endmodule

// File: rtl/hgd_dead_gap.sv
module hgd_dead_gap
  import hgd_pkg::*;
#(
  parameter int DEAD_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  drive_pat_t target_i,
  output logic       gap_o
);
  localparam int CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;

  drive_pat_t    prev_q;
  logic [CW-1:0] cnt_q;
  logic          changed;

  assign changed = (target_i != prev_q);
  assign gap_o   = changed | (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= PAT_OFF;
      cnt_q  <= '0;
    end else begin
      prev_q <= target_i;
      if (changed)           cnt_q <= CW'(DEAD_CYCLES - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hall_gate_driver.sv
module hall_gate_driver
  import hgd_pkg::*;
#(
  parameter int DEAD_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALL_W-1:0] hall_i,
  input  logic              pwm_i,
  input  logic              dir_rev_i,
  input  logic              stop_i,
  input  logic              coast_i,
  input  logic              ilim_i,
  input  logic              fault_i,
  output logic [PHASES-1:0] gate_hi_o,
  output logic [PHASES-1:0] gate_lo_o
);
  drive_pat_t dec_pat;
  drive_pat_t target;
  logic       dec_valid;
  logic       brake;
  logic       chop_ok;
  logic       gap;

  logic [PHASES-1:0] hi_q;
  logic [PHASES-1:0] lo_q;

  hgd_hall_decode u_dec (
    .hall_i  (hall_i),
    .rev_i   (dir_rev_i),
    .pat_o   (dec_pat),
    .valid_o (dec_valid)
  );

  assign brake = stop_i & ~coast_i;

  always_comb begin
    if (stop_i)         target = coast_i ? PAT_OFF : PAT_BRAKE;
    else if (dec_valid) target = dec_pat;
    else                target = PAT_OFF;
  end

  hgd_chop_ctrl u_chop (
    .clk       (clk),
    .rst       (rst),
    .pwm_i     (pwm_i),
    .ilim_i    (ilim_i),
    .fault_i   (fault_i),
    .brake_i   (brake),
    .chop_ok_o (chop_ok)
  );

  hgd_dead_gap #(.DEAD_CYCLES(DEAD_CYCLES)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .target_i (target),
    .gap_o    (gap)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q[p] <= 1'b0;
        lo_q[p] <= 1'b0;
      end else begin
        hi_q[p] <= ~gap & target.src[p] & chop_ok;
        lo_q[p] <= ~gap & target.snk[p];
      end
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;

  // R12: no phase leg conducts through both switches
  a_r12_no_shoot : assert property (@(posedge clk) disable iff (rst)
    (gate_hi_o & gate_lo_o) == '0);

  a_r12_one_sink : assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_lo_o));

  // R10: invalid code in run clears the bridge
  a_r10_invalid_off : assert property (@(posedge clk) disable iff (rst)
    (!stop_i && (hall_i == '0 || hall_i == '1)) |=>
      (gate_hi_o == '0 && gate_lo_o == '0));

  // R6: coasting opens every switch
  a_r6_coast_off : assert property (@(posedge clk) disable iff (rst)
    (stop_i && coast_i) |=> (gate_hi_o == '0 && gate_lo_o == '0));

  // R9: fault removes high-side drive
  a_r9_fault_hi_off : assert property (@(posedge clk) disable iff (rst)
    fault_i |=> (gate_hi_o == '0));

  // R5 / R8: settled brake is full duty on every high side
  a_r5_brake_full : assert property (@(posedge clk) disable iff (rst)
    (stop_i && !coast_i && !fault_i && $past(stop_i && !coast_i)) |=>
      (gate_hi_o == '1 && gate_lo_o == '0));

  // R11: a sink never hands over to another sink without a dead cycle
  a_r11_break_first : assert property (@(posedge clk) disable iff (rst)
    (gate_lo_o != '0) |=> (gate_lo_o == '0 || $stable(gate_lo_o)));
endmodule

// File: tb/hall_gate_driver_tb_top.sv
module hall_gate_driver_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hall = 3'b000;
  logic       pwm = 1'b0, rev = 1'b0, stp = 1'b0, cst = 1'b1, il = 1'b0, flt = 1'b0;
  logic [2:0] hi_o, lo_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hall_gate_driver dut_i (
    .clk(clk), .rst(rst), .hall_i(hall), .pwm_i(pwm), .dir_rev_i(rev),
    .stop_i(stp), .coast_i(cst), .ilim_i(il), .fault_i(flt),
    .gate_hi_o(hi_o), .gate_lo_o(lo_o)
  );

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];

  // reference state kept from the requirements
  logic [5:0] m_prev = '0;
  logic       m_trip = 1'b0;
  logic       m_pwm_d = 1'b0;

  function automatic logic [2:0] ph(input int idx);
    return 3'b001 << idx;
  endfunction

  // R1 table: returns {high-side onehot, low-side onehot}, zero when invalid
  function automatic logic [5:0] table_fwd(input logic [2:0] c);
    int s, k;
    s = -1; k = -1;
    if (c == 3'b101) begin s = 1; k = 0; end
    if (c == 3'b100) begin s = 2; k = 0; end
    if (c == 3'b110) begin s = 2; k = 1; end
    if (c == 3'b010) begin s = 0; k = 1; end
    if (c == 3'b011) begin s = 0; k = 2; end
    if (c == 3'b001) begin s = 1; k = 2; end
    if (s < 0) return 6'b0;
    return {ph(s), ph(k)};
  endfunction

  task automatic drive(input logic [2:0] h, input logic p, input logic r,
                       input logic s, input logic c, input logic i,
                       input logic f, input string tag);
    logic [5:0] tgt, e;
    logic       ps, te, ok, brk;
    item_t      it;
    @(negedge clk);
    hall = h; pwm = p; rev = r; stp = s; cst = c; il = i; flt = f;
    brk = s & ~c;
    if (s)      tgt = c ? 6'b0 : 6'b111_000;
    else        tgt = table_fwd(r ? ~h : h);
    ps = p & ~m_pwm_d;
    te = m_trip & ~ps;
    ok = brk ? ~f : (p & ~i & ~te & ~f);
    if (tgt != m_prev) e = 6'b0;
    else               e = {tgt[5:3] & {3{ok}}, tgt[2:0]};
    m_prev = tgt;
    if (i)       m_trip = 1'b1;
    else if (ps) m_trip = 1'b0;
    m_pwm_d = p;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if ({hi_o, lo_o} !== it.exp) begin
          failures++;
          $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b",
                   it.tag, hi_o, lo_o, it.exp[5:3], it.exp[2:0]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [2:0] fseq [6];
    fseq = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    repeat (4) @(negedge clk);
    // R12: reset state
    checks++;
    if ({hi_o, lo_o} !== 6'b0) begin
      failures++;
      $display("FAIL R12 reset: actual %b expected 000000", {hi_o, lo_o});
    end
    rst = 1'b0;

    // R1 + R11: forward sweep, full gate
    for (int n = 0; n < 2; n++)
      for (int j = 0; j < 6; j++)
        repeat (3) drive(fseq[j], 1, 0, 0, 1, 0, 0, "R1_R11 forward");

    // R3: chopping within one step
    drive(3'b101, 1, 0, 0, 1, 0, 0, "R3 chop");
    drive(3'b101, 0, 0, 0, 1, 0, 0, "R3 chop");
    drive(3'b101, 1, 0, 0, 1, 0, 0, "R3 chop");
    drive(3'b101, 0, 0, 0, 1, 0, 0, "R3 chop");
    drive(3'b101, 0, 0, 0, 1, 0, 0, "R3 chop");

    // R2 + R11: reverse sweep, direction flip mid-step
    for (int j = 0; j < 6; j++)
      repeat (3) drive(fseq[j], 1, 1, 0, 1, 0, 0, "R2 reverse");
    repeat (2) drive(3'b110, 1, 0, 0, 1, 0, 0, "R11 dir flip");
    repeat (2) drive(3'b110, 1, 1, 0, 1, 0, 0, "R11 dir flip");

    // R10: invalid codes
    repeat (3) drive(3'b000, 1, 0, 0, 1, 0, 0, "R10 code 000");
    repeat (2) drive(3'b011, 1, 0, 0, 1, 0, 0, "R10 recover");
    repeat (3) drive(3'b111, 1, 0, 0, 1, 0, 0, "R10 code 111");

    // R7: cycle-by-cycle limit latch
    repeat (2) drive(3'b010, 1, 0, 0, 1, 0, 0, "R7 setup");
    drive(3'b010, 1, 0, 0, 1, 1, 0, "R7 trip now");
    repeat (2) drive(3'b010, 1, 0, 0, 1, 0, 0, "R7 latched");
    repeat (2) drive(3'b010, 0, 0, 0, 1, 0, 0, "R7 off phase");
    repeat (2) drive(3'b010, 1, 0, 0, 1, 0, 0, "R7 new period");

    // R9: fault in run keeps sink
    repeat (3) drive(3'b010, 1, 0, 0, 1, 0, 1, "R9 fault run");
    drive(3'b010, 1, 0, 0, 1, 0, 0, "R9 release");

    // R4 + R6: stop while coasting
    repeat (3) drive(3'b010, 1, 0, 1, 1, 0, 0, "R4_R6 coast");
    repeat (2) drive(3'b100, 1, 0, 0, 1, 0, 0, "R4 run again");

    // R5 + R8 + R9: braking
    repeat (3) drive(3'b100, 0, 0, 1, 0, 1, 0, "R5_R8 brake");
    repeat (2) drive(3'b000, 1, 1, 1, 0, 0, 0, "R5 brake any code");
    repeat (2) drive(3'b100, 0, 0, 1, 0, 0, 1, "R9 fault brake");
    repeat (2) drive(3'b100, 0, 0, 1, 0, 0, 0, "R5 brake resume");
    repeat (2) drive(3'b100, 1, 0, 1, 1, 0, 0, "R6 brake to coast");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule